// File: doc/BRIEF.md
# In-Place 3x3 Mean Filter Engine

This engine smooths a grayscale picture that sits in an external source RAM. It replaces each pixel with the integer mean of its 3x3 neighbourhood and writes the results into a second RAM of the same size. A copy phase then moves the whole result back into the source RAM. After that, the picture in the source RAM is the smoothed one, so a display that scans the source RAM shows the result, and the next start filters it again. Each pass blurs the picture a little more.

The engine controls both RAMs directly. It drives their addresses, write data and write enables, and it takes their read data one cycle after it presents an address. A one-cycle `start` pulse begins a pass. `busy` stays high for the whole pass, and `done` pulses for one cycle at the end. Each pixel costs 13 cycles: ten fetch cycles, one sum, one divide and one write. The copy-back costs one cycle per pixel plus one.

Top module: `box_blur_engine`

## Requirements
- R1: After reset, `busy`, `done`, `srcWrEn` and `dstWrEn` are all low.
- R2: A `start` sampled high while idle makes `busy` high from the next cycle. `busy` stays high through the cycle in which `done` is high.
- R3: Pixel (row r, column c) lives at address r*2^COL_BITS + c. After a pass, the destination RAM holds at each address the floor of the sum of the nine neighbours divided by 9, where the neighbours are rows r-1..r+1 and columns c-1..c+1.
- R4: At the picture edges, a neighbour row or column is clamped into 0..rows-1 or 0..cols-1. A corner pixel therefore counts itself four times.
- R5: The divide by 9 is exact floor division for every sum from 0 to 9*(2^PIX_W-1). A field of 255s stays at 255.
- R6: When `done` rises, the source RAM holds the same filtered picture as the destination RAM.
- R7: With N pixels, `done` is high for exactly one cycle, 14*N+2 cycles after the clock edge that accepts `start`.
- R8: A `start` that arrives while `busy` is high, including the cycle in which `done` is high, is ignored. It causes no second pass, does not change the latency, and does not restart the engine after `done`.
- R9: Back-to-back passes without reloading each apply the filter once more to the previous result.
- R10: During filtering, only the destination RAM is written, and each address is written exactly once. During copy-back, only the source RAM is written, and each address is written exactly once, all after the last destination write. The two write enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a pass when idle |
| busy | output | 1 | High while a pass is running |
| done | output | 1 | One-cycle pulse at the end of a pass |
| srcAddr | output | ROW_BITS+COL_BITS | Source RAM address |
| srcWrEn | output | 1 | Source RAM write enable (copy-back) |
| srcWrData | output | PIX_W | Source RAM write data |
| srcRdData | input | PIX_W | Source RAM read data, one cycle after the address |
| dstAddr | output | ROW_BITS+COL_BITS | Destination RAM address |
| dstWrEn | output | 1 | Destination RAM write enable (filtering) |
| dstWrData | output | PIX_W | Filtered pixel |
| dstRdData | input | PIX_W | Destination RAM read data, one cycle after the address |

## Verification
The hardest situation to reach from the ports is a `start` pulse that arrives during the single `done` cycle. At that moment the engine is about to fall idle, so a careless decode would start a second pass. The bench produces this case by watching for `done` and raising `start` in that same cycle. It then keeps checking that `busy` stays low. Further `start` pulses land at regular points inside the pass. The bench checks that the cycle count is unchanged and that the picture was filtered only once. Border clamping uses a grid with more columns than rows, so a swapped row and column shows up as wrong edge pixels.

// File: rtl/box_blur_pkg.sv
package box_blur_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_SUM,
    PH_DIV,
    PH_WRITE,
    PH_COPY,
    PH_DONE
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrPix;
    logic incPix;
    logic clrTap;
    logic fetch;
    logic doSum;
    logic doDiv;
    logic writeDst;
    logic clrCopy;
    logic copyMode;
    logic copyWrite;
  } strobe_t;

  // Row offset selector of a tap: 0 = up, 1 = same, 2 = down
  function automatic logic [1:0] tapRowSel(input logic [3:0] t);
    if (t >= 4'd6) return 2'd2;
    else if (t >= 4'd3) return 2'd1;
    else return 2'd0;
  endfunction

  // Column offset selector of a tap: 0 = left, 1 = same, 2 = right
  function automatic logic [1:0] tapColSel(input logic [3:0] t);
    logic [3:0] rowPart;
    rowPart = 4'(tapRowSel(t)) * 4'd3;
    return 2'(t - rowPart);
  endfunction

endpackage

// File: rtl/box_blur_clamp.sv
module box_blur_clamp #(
  parameter int W = 8
) (
  input  logic [W-1:0] base,
  input  logic [1:0]   sel,
  output logic [W-1:0] pos
);
  always_comb begin
    case (sel)
      2'd0:    pos = (base == '0) ? base : base - W'(1);
      2'd2:    pos = (base == '1) ? base : base + W'(1);
      default: pos = base;
    endcase
  end
endmodule

// File: rtl/box_blur_ctrl.sv
module box_blur_ctrl
  import box_blur_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    tapLast,
  input  logic    pixLast,
  input  logic    copyFirst,
  input  logic    copyLast,
  output strobe_t st,
  output logic    busy,
  output logic    done
);
  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    st        = '0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          st.clrPix = 1'b1;
          st.clrTap = 1'b1;
          phaseNext = PH_FETCH;
        end
      end
      PH_FETCH: begin
        st.fetch = 1'b1;
        if (tapLast) phaseNext = PH_SUM;
      end
      PH_SUM: begin
        st.doSum  = 1'b1;
        phaseNext = PH_DIV;
      end
      PH_DIV: begin
        st.doDiv  = 1'b1;
        phaseNext = PH_WRITE;
      end
      PH_WRITE: begin
        st.writeDst = 1'b1;
        if (pixLast) begin
          st.clrCopy = 1'b1;
          phaseNext  = PH_COPY;
        end else begin
          st.incPix = 1'b1;
          st.clrTap = 1'b1;
          phaseNext = PH_FETCH;
        end
      end
      PH_COPY: begin
        st.copyMode  = 1'b1;
        st.copyWrite = !copyFirst;
        if (copyLast) phaseNext = PH_DONE;
      end
      PH_DONE:  phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_DONE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R10
  copy_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COPY) |=> (phase == PH_COPY || phase == PH_DONE));
endmodule

// File: rtl/box_blur_datapath.sv
module box_blur_datapath
  import box_blur_pkg::*;
#(
  parameter int COL_BITS = 8,
  parameter int ROW_BITS = 8,
  parameter int PIX_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      st,
  output logic                         tapLast,
  output logic                         pixLast,
  output logic                         copyFirst,
  output logic                         copyLast,
  output logic [ROW_BITS+COL_BITS-1:0] srcAddr,
  output logic                         srcWrEn,
  output logic [PIX_W-1:0]             srcWrData,
  input  logic [PIX_W-1:0]             srcRdData,
  output logic [ROW_BITS+COL_BITS-1:0] dstAddr,
  output logic                         dstWrEn,
  output logic [PIX_W-1:0]             dstWrData,
  input  logic [PIX_W-1:0]             dstRdData
);
  localparam int ADDR_W    = ROW_BITS + COL_BITS;
  localparam int CNT_W     = ADDR_W + 1;
  localparam int PIX_COUNT = 1 << ADDR_W;
  localparam int TAPS      = 9;
  localparam int SUM_W     = PIX_W + 4;
  localparam int DIV_SHIFT = SUM_W + 4;
  localparam int RECIP     = ((1 << DIV_SHIFT) + 8) / 9;
  localparam int PROD_W    = SUM_W + DIV_SHIFT;

  logic [ADDR_W-1:0]   pixIdx;
  logic [3:0]          tap;
  logic [PIX_W-1:0]    nbr [TAPS];
  logic [SUM_W-1:0]    sumReg, sumNext;
  logic [PIX_W-1:0]    quot, quotNext;
  logic [PROD_W-1:0]   prod;
  logic [CNT_W-1:0]    copyCnt;

  logic [ROW_BITS-1:0] pixRow, nbrRow;
  logic [COL_BITS-1:0] pixCol, nbrCol;
  logic [3:0]          tapIdx;
  logic [ADDR_W-1:0]   nbrAddr, copyWrAddr;

  assign pixRow = pixIdx[ADDR_W-1:COL_BITS];
  assign pixCol = pixIdx[COL_BITS-1:0];
  assign tapIdx = (tap > 4'd8) ? 4'd8 : tap;

  box_blur_clamp #(.W(ROW_BITS)) u_rowClamp (
    .base(pixRow), .sel(tapRowSel(tapIdx)), .pos(nbrRow));
  box_blur_clamp #(.W(COL_BITS)) u_colClamp (
    .base(pixCol), .sel(tapColSel(tapIdx)), .pos(nbrCol));

  assign nbrAddr = {nbrRow, nbrCol};

  // Pixel and tap counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixIdx <= '0;
      tap    <= '0;
    end else begin
      if (st.clrPix)      pixIdx <= '0;
      else if (st.incPix) pixIdx <= pixIdx + ADDR_W'(1);
      if (st.clrTap)      tap <= '0;
      else if (st.fetch)  tap <= tap + 4'd1;
    end
  end

  assign tapLast = (tap == 4'd9);
  assign pixLast = (pixIdx == '1);

  // Neighbour capture: data for tap g arrives while tap == g+1
  for (genvar g = 0; g < TAPS; g++) begin : g_nbr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) nbr[g] <= '0;
      else if (st.fetch && tap == 4'(g + 1)) nbr[g] <= srcRdData;
    end
  end

  always_comb begin
    sumNext = '0;
    for (int i = 0; i < TAPS; i++) sumNext = sumNext + SUM_W'(nbr[i]);
  end

  assign prod     = PROD_W'(sumReg) * PROD_W'(RECIP);
  assign quotNext = PIX_W'(prod >> DIV_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
      quot   <= '0;
    end else begin
      if (st.doSum) sumReg <= sumNext;
      if (st.doDiv) quot   <= quotNext;
    end
  end

  // Copy-back counter: reads lead writes by one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            copyCnt <= '0;
    else if (st.clrCopy)  copyCnt <= '0;
    else if (st.copyMode) copyCnt <= copyCnt + CNT_W'(1);
  end

  assign copyFirst  = (copyCnt == '0);
  assign copyLast   = (copyCnt == CNT_W'(PIX_COUNT));
  assign copyWrAddr = copyCnt[ADDR_W-1:0] - ADDR_W'(1);

  assign srcAddr   = st.copyMode ? copyWrAddr : nbrAddr;
  assign srcWrEn   = st.copyWrite;
  assign srcWrData = dstRdData;
  assign dstAddr   = st.copyMode ? copyCnt[ADDR_W-1:0] : pixIdx;
  assign dstWrEn   = st.writeDst;
  assign dstWrData = quot;

  // R5
  div_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.writeDst |-> ((int'(quot) * 9 <= int'(sumReg)) &&
                     (int'(sumReg) < int'(quot) * 9 + 9)));

  // R4
  nbr_near_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.fetch && tap < 4'd9) |->
      ((int'(nbrRow) - int'(pixRow) <= 1) && (int'(pixRow) - int'(nbrRow) <= 1) &&
       (int'(nbrCol) - int'(pixCol) <= 1) && (int'(pixCol) - int'(nbrCol) <= 1)));

  // R10
  wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(srcWrEn && dstWrEn));
endmodule

// File: rtl/box_blur_engine.sv
module box_blur_engine
  import box_blur_pkg::*;
#(
  parameter int COL_BITS = 8,
  parameter int ROW_BITS = 8,
  parameter int PIX_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic [ROW_BITS+COL_BITS-1:0] srcAddr,
  output logic                         srcWrEn,
  output logic [PIX_W-1:0]             srcWrData,
  input  logic [PIX_W-1:0]             srcRdData,
  output logic [ROW_BITS+COL_BITS-1:0] dstAddr,
  output logic                         dstWrEn,
  output logic [PIX_W-1:0]             dstWrData,
  input  logic [PIX_W-1:0]             dstRdData
);
  strobe_t st;
  logic    tapLast, pixLast, copyFirst, copyLast;

  box_blur_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .tapLast(tapLast), .pixLast(pixLast),
    .copyFirst(copyFirst), .copyLast(copyLast),
    .st(st), .busy(busy), .done(done));

  box_blur_datapath #(
    .COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS), .PIX_W(PIX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .tapLast(tapLast), .pixLast(pixLast),
    .copyFirst(copyFirst), .copyLast(copyLast),
    .srcAddr(srcAddr), .srcWrEn(srcWrEn), .srcWrData(srcWrData),
    .srcRdData(srcRdData),
    .dstAddr(dstAddr), .dstWrEn(dstWrEn), .dstWrData(dstWrData),
    .dstRdData(dstRdData));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!srcWrEn && !dstWrEn && !done));
endmodule

// File: tb/box_blur_engine_bench.sv
`timescale 1ns/1ps
module box_blur_engine_bench;
  localparam int COLB = 4;
  localparam int ROWB = 3;
  localparam int PW   = 8;
  localparam int AW   = ROWB + COLB;
  localparam int COLS = 1 << COLB;
  localparam int ROWS = 1 << ROWB;
  localparam int NPIX = 1 << AW;
  localparam int LAT  = 14 * NPIX + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, start, busy, done;
  logic [AW-1:0] srcAddr, dstAddr;
  logic          srcWrEn, dstWrEn;
  logic [PW-1:0] srcWrData, srcRdData, dstWrData, dstRdData;

  box_blur_engine #(.COL_BITS(COLB), .ROW_BITS(ROWB), .PIX_W(PW)) u_box_blur_engine (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .srcAddr(srcAddr), .srcWrEn(srcWrEn), .srcWrData(srcWrData), .srcRdData(srcRdData),
    .dstAddr(dstAddr), .dstWrEn(dstWrEn), .dstWrData(dstWrData), .dstRdData(dstRdData));

  // RAM models, one-cycle read latency
  logic [PW-1:0] srcMem [NPIX];
  logic [PW-1:0] dstMem [NPIX];
  always @(posedge clk) begin
    if (srcWrEn) srcMem[srcAddr] <= srcWrData;
    srcRdData <= srcMem[srcAddr];
    if (dstWrEn) dstMem[dstAddr] <= dstWrData;
    dstRdData <= dstMem[dstAddr];
  end

  int checks = 0;
  int errors = 0;
  int refImg [NPIX];
  int expImg [NPIX];

  // Write monitor
  bit monOn = 1'b0;
  int dstWrCnt, srcWrCnt, dupDst, dupSrc, earlySrc, bothWr;
  bit dstHit [NPIX];
  bit srcHit [NPIX];

  always @(negedge clk) begin
    if (monOn) begin
      if (srcWrEn && dstWrEn) bothWr++;
      if (dstWrEn) begin
        dstWrCnt++;
        if (dstHit[dstAddr]) dupDst++;
        dstHit[dstAddr] = 1'b1;
      end
      if (srcWrEn) begin
        srcWrCnt++;
        if (dstWrCnt < NPIX) earlySrc++;
        if (srcHit[srcAddr]) dupSrc++;
        srcHit[srcAddr] = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampI(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic computeExpected();
    for (int i = 0; i < NPIX; i++) refImg[i] = int'(srcMem[i]);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int s;
        s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            s += refImg[clampI(r + dr, ROWS - 1) * COLS + clampI(c + dc, COLS - 1)];
        expImg[r * COLS + c] = s / 9;
      end
    end
  endtask

  function automatic bit isBorder(input int i);
    int r, c;
    r = i / COLS;
    c = i % COLS;
    return (r == 0 || c == 0 || r == ROWS - 1 || c == COLS - 1);
  endfunction

  task automatic compareImages(input string tag);
    int badIn, badBd, badSrc, fi, fb, fs;
    badIn = 0; badBd = 0; badSrc = 0; fi = 0; fb = 0; fs = 0;
    for (int i = 0; i < NPIX; i++) begin
      if (int'(dstMem[i]) != expImg[i]) begin
        if (isBorder(i)) begin if (badBd == 0) fb = i; badBd++; end
        else begin if (badIn == 0) fi = i; badIn++; end
      end
      if (int'(srcMem[i]) != expImg[i]) begin
        if (badSrc == 0) fs = i;
        badSrc++;
      end
    end
    check(badIn == 0, "R3 R5", {tag, " interior pixel"}, int'(dstMem[fi]), expImg[fi]);
    check(badBd == 0, "R4", {tag, " border pixel"}, int'(dstMem[fb]), expImg[fb]);
    check(badSrc == 0, "R6", {tag, " copied-back pixel"}, int'(srcMem[fs]), expImg[fs]);
  endtask

  task automatic runPass(input string tag, input bit extraStarts);
    int k, busyDrop;
    bit sawDone;
    computeExpected();
    dstWrCnt = 0; srcWrCnt = 0; dupDst = 0; dupSrc = 0; earlySrc = 0; bothWr = 0;
    for (int i = 0; i < NPIX; i++) begin dstHit[i] = 1'b0; srcHit[i] = 1'b0; end
    monOn = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 1;
    busyDrop = 0;
    check(busy == 1'b1, "R2", {tag, " busy after start"}, int'(busy), 1);
    while (!done && k < LAT + 50) begin
      start = extraStarts && (k % 97 == 0);
      @(negedge clk);
      k++;
      if (!busy) busyDrop++;
    end
    sawDone = done;
    check(sawDone && k == LAT, "R7", {tag, " done latency"}, k, LAT);
    check(busyDrop == 0, "R2", {tag, " busy gaps"}, busyDrop, 0);
    // start during the done cycle must not restart
    start = extraStarts;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R7", {tag, " done width"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R8", {tag, " idle after pass"}, int'(busy), 0);
    monOn = 1'b0;
    check(dstWrCnt == NPIX && dupDst == 0, "R10", {tag, " dst writes"}, dstWrCnt - dupDst, NPIX);
    check(srcWrCnt == NPIX && dupSrc == 0 && earlySrc == 0, "R10", {tag, " src writes"},
          srcWrCnt - dupSrc - earlySrc, NPIX);
    check(bothWr == 0, "R10", {tag, " write overlap"}, bothWr, 0);
    compareImages(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NPIX; i++) begin srcMem[i] = '0; dstMem[i] = '0; end
    rstN = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1", "status at reset", int'(busy) + int'(done), 0);
    check(!srcWrEn && !dstWrEn, "R1", "write enables at reset", int'(srcWrEn) + int'(dstWrEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !srcWrEn && !dstWrEn, "R1", "idle after reset", int'(busy), 0);

    // R5: full-scale field, maximum sum
    for (int i = 0; i < NPIX; i++) srcMem[i] = 8'hFF;
    runPass("full-scale", 1'b1);

    // R4: checkerboard with a bright corner exercises clamping
    for (int i = 0; i < NPIX; i++)
      srcMem[i] = (((i / COLS) + (i % COLS)) % 2 == 1) ? 8'd255 : 8'd0;
    srcMem[0] = 8'd200;
    srcMem[NPIX - 1] = 8'd7;
    runPass("checker", 1'b0);
    // R9: iterate on the previous result
    runPass("checker second pass R9", 1'b1);

    // random image, then two more iterations (R9)
    for (int i = 0; i < NPIX; i++) srcMem[i] = 8'($urandom);
    runPass("random", 1'b1);
    runPass("random iter R9", 1'b0);
    runPass("random iter3 R9", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule